// File: doc/BRIEF.md
# Flag-Gated 8-Bit Asynchronous Serial Port

This block is a full-duplex asynchronous serial port with one character format. A character is ten bits long: a low start bit, eight data bits with the least significant bit first, and a high stop bit. Software starts a transmission by writing a byte to the transmit buffer. Received bytes appear in a receive buffer. Two sticky flags record that work has finished. The transmit flag sets when the stop bit begins. The receive flag sets when a byte has been accepted. A combined interrupt request is asserted while either flag is set and interrupts are enabled.

The receive path is gated by its flag. A byte is committed only while the receive flag is clear. When the stop-check option is on, the sampled stop bit must also be high. If the byte is not committed, the buffer, the stop status bit and the flag all stay as they were. The byte already waiting in the buffer therefore survives an overrun. The oversampling tick comes from outside at sixteen ticks per bit. The receiver re-checks the start bit at its midpoint and samples every other bit at its centre.

Software writes a configuration word that sets the receive enable and the stop-check enable. The same word clears either flag where it carries a 0. A 1 in a flag position leaves that flag unchanged.

Top module: `uartFlagGated`

## Requirements
- R1: The serial output idles at 1. A frame is a 0 start bit, then the 8 data bits with bit 0 first, then a 1 stop bit. Each bit lasts 16 baud ticks.
- R2: The transmit flag is 0 through the last data bit. It rises in the same clock in which the serial output goes to the stop level.
- R3: A transmit-buffer write made while a frame is being sent has no effect: the frame in progress is unchanged and no further frame follows it.
- R4: A start edge is accepted only while receive enable is 1. A frame that arrives while it is 0 leaves the flag, the buffer and the stop status unchanged.
- R5: When the receive flag is 0 and the stop-check condition holds at the stop-bit centre, the buffer takes the 8 data bits, the stop status takes the sampled stop bit, and the receive flag becomes 1.
- R6: While the receive flag is 1, a further incoming frame is discarded and the buffer keeps the earlier byte.
- R7: With stop-check on, a frame whose stop bit samples 0 is not committed: the buffer, the stop status and the flag do not change. With stop-check off, such a frame is committed with stop status 0.
- R8: A low level on the receive line that has ended by the start-bit midpoint (8 ticks) is a false start. It produces no reception, and the next valid frame is received normally.
- R9: A configuration write clears a flag whose bit is written 0. A 1 leaves the flag unchanged. Neither flag ever clears itself.
- R10: The interrupt request is 1 exactly when interrupt enable is 1 and at least one flag is 1.
- R11: After reset the serial output is 1, both flags, both enables, the buffer, the stop status and the interrupt request are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| baudTick | input | 1 | One-clock pulse at 16 times the bit rate |
| rxLine | input | 1 | Serial receive line |
| txLine | output | 1 | Serial transmit line |
| txWrite | input | 1 | Transmit-buffer write strobe |
| txData | input | 8 | Byte to transmit |
| cfgWrite | input | 1 | Configuration write strobe |
| cfgRxEnable | input | 1 | Receive enable value written |
| cfgStopCheck | input | 1 | Stop-check enable value written |
| cfgTxFlag | input | 1 | Transmit flag bit written (0 clears) |
| cfgRxFlag | input | 1 | Receive flag bit written (0 clears) |
| irqEnable | input | 1 | Interrupt enable |
| rxEnable | output | 1 | Current receive enable |
| stopCheck | output | 1 | Current stop-check enable |
| txFlag | output | 1 | Transmit-done flag |
| rxFlag | output | 1 | Receive-done flag |
| rxStopBit | output | 1 | Stop bit of the last committed frame |
| rxBuffer | output | 8 | Last committed received byte |
| irq | output | 1 | Combined interrupt request |

## Verification
The serial output goes low on the clock edge that accepts the write. Each bit then ends on the 16th tick of its period, so the tick phase moves every bit boundary by up to one tick. The bench therefore samples the output at bit centres, 32 clocks plus 64 per bit after the write, and checks the transmit flag at the centres of the last data bit and the stop bit. On the receive side, the commit happens at the stop-bit centre after the two-stage synchronizer and the tick phase. The bench checks the buffer, the stop status and the flags only after the whole frame and an idle bit have passed. Configuration and interrupt results are due one clock or less after the stimulus and are read at the next falling edge.

// File: rtl/uartFgPkg.sv
package uartFgPkg;

  typedef struct packed {
    logic txLoad;     // accept byte, drive start level
    logic txShift;    // put next data bit on the line
    logic txStop;     // drive stop level, raise transmit flag
    logic rxShiftIn;  // capture a data bit at its centre
    logic rxEnd;      // stop-bit centre: commit decision
  } uartStrobes_t;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_START = 2'd1,
    PH_DATA  = 2'd2,
    PH_STOP  = 2'd3
  } framePhase_t;

endpackage

// File: rtl/uartFgControl.sv
module uartFgControl
  import uartFgPkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_BITS  = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         baudTick,
  input  logic         txWrite,
  input  logic         rxBit,
  input  logic         rxEnable,
  output uartStrobes_t strobes
);

  localparam int TICK_W = $clog2(OVERSAMPLE);
  localparam int BIT_W  = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(OVERSAMPLE - 1);
  localparam logic [TICK_W-1:0] HALF_LAST = TICK_W'(OVERSAMPLE / 2 - 1);
  localparam logic [BIT_W-1:0]  BIT_LAST  = BIT_W'(DATA_BITS - 1);

  framePhase_t       txPhase;
  logic [TICK_W-1:0] txTick;
  logic [BIT_W-1:0]  txBitIdx;
  framePhase_t       rxPhase;
  logic [TICK_W-1:0] rxTick;
  logic [BIT_W-1:0]  rxBitIdx;

  logic txBitEnd;
  logic rxBitEnd;

  assign txBitEnd = baudTick && (txTick == TICK_LAST);
  assign rxBitEnd = baudTick && (rxTick == TICK_LAST);

  // Transmit sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txPhase  <= PH_IDLE;
      txTick   <= '0;
      txBitIdx <= '0;
    end else begin
      unique case (txPhase)
        PH_IDLE: begin
          if (txWrite) begin
            txPhase <= PH_START;
            txTick  <= '0;
          end
        end
        PH_START: begin
          if (txBitEnd) begin
            txPhase  <= PH_DATA;
            txTick   <= '0;
            txBitIdx <= '0;
          end else if (baudTick) begin
            txTick <= txTick + 1'b1;
          end
        end
        PH_DATA: begin
          if (txBitEnd) begin
            txTick <= '0;
            if (txBitIdx == BIT_LAST) begin
              txPhase <= PH_STOP;
            end else begin
              txBitIdx <= txBitIdx + 1'b1;
            end
          end else if (baudTick) begin
            txTick <= txTick + 1'b1;
          end
        end
        PH_STOP: begin
          if (txBitEnd) begin
            txPhase <= PH_IDLE;
            txTick  <= '0;
          end else if (baudTick) begin
            txTick <= txTick + 1'b1;
          end
        end
        default: txPhase <= PH_IDLE;
      endcase
    end
  end

  // Receive sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxPhase  <= PH_IDLE;
      rxTick   <= '0;
      rxBitIdx <= '0;
    end else begin
      unique case (rxPhase)
        PH_IDLE: begin
          if (baudTick && rxEnable && !rxBit) begin
            rxPhase <= PH_START;
            rxTick  <= '0;
          end
        end
        PH_START: begin
          if (baudTick) begin
            if (rxTick == HALF_LAST) begin
              rxTick   <= '0;
              rxBitIdx <= '0;
              rxPhase  <= rxBit ? PH_IDLE : PH_DATA;
            end else begin
              rxTick <= rxTick + 1'b1;
            end
          end
        end
        PH_DATA: begin
          if (rxBitEnd) begin
            rxTick <= '0;
            if (rxBitIdx == BIT_LAST) begin
              rxPhase <= PH_STOP;
            end else begin
              rxBitIdx <= rxBitIdx + 1'b1;
            end
          end else if (baudTick) begin
            rxTick <= rxTick + 1'b1;
          end
        end
        PH_STOP: begin
          if (rxBitEnd) begin
            rxPhase <= PH_IDLE;
            rxTick  <= '0;
          end else if (baudTick) begin
            rxTick <= rxTick + 1'b1;
          end
        end
        default: rxPhase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes           = '0;
    strobes.txLoad    = (txPhase == PH_IDLE) && txWrite;
    strobes.txShift   = txBitEnd && ((txPhase == PH_START) ||
                        ((txPhase == PH_DATA) && (txBitIdx != BIT_LAST)));
    strobes.txStop    = txBitEnd && (txPhase == PH_DATA) && (txBitIdx == BIT_LAST);
    strobes.rxShiftIn = rxBitEnd && (rxPhase == PH_DATA);
    strobes.rxEnd     = rxBitEnd && (rxPhase == PH_STOP);
  end

endmodule

// File: rtl/uartFgDatapath.sv
module uartFgDatapath
  import uartFgPkg::*;
#(
  parameter int DATA_BITS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  uartStrobes_t         strobes,
  input  logic [DATA_BITS-1:0] txData,
  input  logic                 rxLine,
  input  logic                 cfgWrite,
  input  logic                 cfgRxEnable,
  input  logic                 cfgStopCheck,
  input  logic                 cfgTxFlag,
  input  logic                 cfgRxFlag,
  output logic                 rxBit,
  output logic                 txLine,
  output logic                 rxEnable,
  output logic                 stopCheck,
  output logic                 txFlag,
  output logic                 rxFlag,
  output logic                 rxStopBit,
  output logic [DATA_BITS-1:0] rxBuffer
);

  logic [SYNC_STAGES-1:0] syncReg;
  logic [DATA_BITS-1:0]   txShiftReg;
  logic [DATA_BITS-1:0]   rxShiftReg;
  logic                   rxCommit;

  // Receive line synchronizer, idles at the mark level
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncReg <= '1;
    else       syncReg <= {syncReg[SYNC_STAGES-2:0], rxLine};
  end
  assign rxBit = syncReg[SYNC_STAGES-1];

  // Transmit shifter and line driver
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShiftReg <= '0;
      txLine     <= 1'b1;
    end else if (strobes.txLoad) begin
      txShiftReg <= txData;
      txLine     <= 1'b0;
    end else if (strobes.txShift) begin
      txLine     <= txShiftReg[0];
      txShiftReg <= txShiftReg >> 1;
    end else if (strobes.txStop) begin
      txLine     <= 1'b1;
    end
  end

  // Receive shifter, least significant bit arrives first
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  rxShiftReg <= '0;
    else if (strobes.rxShiftIn) rxShiftReg <= {rxBit, rxShiftReg[DATA_BITS-1:1]};
  end

  assign rxCommit = strobes.rxEnd && !rxFlag && (!stopCheck || rxBit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxBuffer  <= '0;
      rxStopBit <= 1'b0;
    end else if (rxCommit) begin
      rxBuffer  <= rxShiftReg;
      rxStopBit <= rxBit;
    end
  end

  // Configuration and sticky flags; a hardware set wins over a clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxEnable  <= 1'b0;
      stopCheck <= 1'b0;
      txFlag    <= 1'b0;
      rxFlag    <= 1'b0;
    end else begin
      if (cfgWrite) begin
        rxEnable  <= cfgRxEnable;
        stopCheck <= cfgStopCheck;
      end
      if (strobes.txStop)            txFlag <= 1'b1;
      else if (cfgWrite && !cfgTxFlag) txFlag <= 1'b0;
      if (rxCommit)                  rxFlag <= 1'b1;
      else if (cfgWrite && !cfgRxFlag) rxFlag <= 1'b0;
    end
  end

endmodule

// File: rtl/uartFlagGated.sv
module uartFlagGated
  import uartFgPkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int DATA_BITS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 baudTick,
  input  logic                 rxLine,
  output logic                 txLine,
  input  logic                 txWrite,
  input  logic [DATA_BITS-1:0] txData,
  input  logic                 cfgWrite,
  input  logic                 cfgRxEnable,
  input  logic                 cfgStopCheck,
  input  logic                 cfgTxFlag,
  input  logic                 cfgRxFlag,
  input  logic                 irqEnable,
  output logic                 rxEnable,
  output logic                 stopCheck,
  output logic                 txFlag,
  output logic                 rxFlag,
  output logic                 rxStopBit,
  output logic [DATA_BITS-1:0] rxBuffer,
  output logic                 irq
);

  uartStrobes_t strobes;
  logic         rxBit;

  uartFgControl #(
    .OVERSAMPLE(OVERSAMPLE),
    .DATA_BITS (DATA_BITS)
  ) ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .baudTick(baudTick),
    .txWrite (txWrite),
    .rxBit   (rxBit),
    .rxEnable(rxEnable),
    .strobes (strobes)
  );

  uartFgDatapath #(
    .DATA_BITS  (DATA_BITS),
    .SYNC_STAGES(SYNC_STAGES)
  ) dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .txData      (txData),
    .rxLine      (rxLine),
    .cfgWrite    (cfgWrite),
    .cfgRxEnable (cfgRxEnable),
    .cfgStopCheck(cfgStopCheck),
    .cfgTxFlag   (cfgTxFlag),
    .cfgRxFlag   (cfgRxFlag),
    .rxBit       (rxBit),
    .txLine      (txLine),
    .rxEnable    (rxEnable),
    .stopCheck   (stopCheck),
    .txFlag      (txFlag),
    .rxFlag      (rxFlag),
    .rxStopBit   (rxStopBit),
    .rxBuffer    (rxBuffer)
  );

  assign irq = irqEnable & (txFlag | rxFlag);

endmodule

// File: rtl/uartFlagGatedChecker.sv
module uartFlagGatedChecker #(
  parameter int DATA_BITS = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 txLine,
  input logic                 cfgWrite,
  input logic                 cfgTxFlag,
  input logic                 cfgRxFlag,
  input logic                 irqEnable,
  input logic                 stopCheck,
  input logic                 txFlag,
  input logic                 rxFlag,
  input logic                 rxStopBit,
  input logic [DATA_BITS-1:0] rxBuffer,
  input logic                 irq
);

  AST_TXFLAG_AT_STOP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txFlag) |-> txLine); // R2

  AST_BUFFER_HELD: assert property (@(posedge clk) disable iff (!rstN)
    $past(rxFlag) |-> $stable(rxBuffer)); // R6

  AST_STATUS_WITH_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rxStopBit) |-> (rxFlag && !$past(rxFlag))); // R5

  AST_STOP_CHECKED: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(rxFlag) && $past(stopCheck)) |-> rxStopBit); // R7

  AST_RXFLAG_CLEAR_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rxFlag) |-> $past(cfgWrite && !cfgRxFlag)); // R9

  AST_TXFLAG_CLEAR_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txFlag) |-> $past(cfgWrite && !cfgTxFlag)); // R9

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    !irqEnable |-> !irq); // R10

  AST_IRQ_ON_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (irqEnable && (rxFlag || txFlag)) |-> irq); // R10

endmodule

bind uartFlagGated uartFlagGatedChecker #(.DATA_BITS(DATA_BITS)) chk (
  .clk      (clk),
  .rstN     (rstN),
  .txLine   (txLine),
  .cfgWrite (cfgWrite),
  .cfgTxFlag(cfgTxFlag),
  .cfgRxFlag(cfgRxFlag),
  .irqEnable(irqEnable),
  .stopCheck(stopCheck),
  .txFlag   (txFlag),
  .rxFlag   (rxFlag),
  .rxStopBit(rxStopBit),
  .rxBuffer (rxBuffer),
  .irq      (irq)
);

// File: tb/uartFlagGated_test.sv
module uartFlagGated_test;

  localparam int BIT_CLKS = 64;  // 16 ticks of 4 clocks each

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       baudTick = 1'b0;
  logic       rxLine = 1'b1;
  logic       txLine;
  logic       txWrite = 1'b0;
  logic [7:0] txData = '0;
  logic       cfgWrite = 1'b0;
  logic       cfgRxEnable = 1'b0;
  logic       cfgStopCheck = 1'b0;
  logic       cfgTxFlag = 1'b1;
  logic       cfgRxFlag = 1'b1;
  logic       irqEnable = 1'b0;
  logic       rxEnable, stopCheck, txFlag, rxFlag, rxStopBit, irq;
  logic [7:0] rxBuffer;

  int checks = 0;
  int errors = 0;
  int tickCnt = 0;

  uartFlagGated uut (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .rxLine(rxLine), .txLine(txLine),
    .txWrite(txWrite), .txData(txData), .cfgWrite(cfgWrite), .cfgRxEnable(cfgRxEnable),
    .cfgStopCheck(cfgStopCheck), .cfgTxFlag(cfgTxFlag), .cfgRxFlag(cfgRxFlag),
    .irqEnable(irqEnable), .rxEnable(rxEnable), .stopCheck(stopCheck), .txFlag(txFlag),
    .rxFlag(rxFlag), .rxStopBit(rxStopBit), .rxBuffer(rxBuffer), .irq(irq)
  );

  always #5 clk = ~clk;

  always @(negedge clk) begin
    tickCnt  = (tickCnt + 1) % 4;
    baudTick = (tickCnt == 0);
  end

  function automatic logic expTxBit(input logic [7:0] d, input int k);
    if (k == 0) return 1'b0;
    if (k <= 8) return d[k-1];
    return 1'b1;
  endfunction

  function automatic logic expCommit(input logic flagBefore, input logic chk, input logic stopVal);
    return !flagBefore && (!chk || stopVal);
  endfunction

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg(input logic en, input logic chk, input logic tiW, input logic riW);
    @(negedge clk);
    cfgRxEnable = en; cfgStopCheck = chk; cfgTxFlag = tiW; cfgRxFlag = riW; cfgWrite = 1'b1;
    @(negedge clk);
    cfgWrite = 1'b0; cfgTxFlag = 1'b1; cfgRxFlag = 1'b1;
  endtask

  task automatic txFrame(input logic [7:0] d, input logic intrude);
    @(negedge clk);
    txData = d; txWrite = 1'b1;
    @(negedge clk);
    txWrite = 1'b0;
    repeat (31) @(negedge clk);
    for (int k = 0; k < 10; k++) begin
      check(txLine === expTxBit(d, k), $sformatf("R1 tx bit %0d", k), txLine, expTxBit(d, k));
      if (k == 8) check(txFlag === 1'b0, "R2 flag low in last data bit", txFlag, 0);
      if (k == 9) check(txFlag === 1'b1, "R2 flag high in stop bit", txFlag, 1);
      if (intrude && k == 3) begin txData = ~d; txWrite = 1'b1; end
      @(negedge clk);
      txWrite = 1'b0;
      repeat (BIT_CLKS - 1) @(negedge clk);
    end
    if (intrude) begin
      for (int s = 0; s < 4; s++) begin
        repeat (32) @(negedge clk);
        check(txLine === 1'b1, "R3 no frame after ignored write", txLine, 1);
      end
    end
  endtask

  task automatic rxFrame(input logic [7:0] d, input logic stopVal);
    @(negedge clk);
    rxLine = 1'b0;
    repeat (BIT_CLKS) @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      rxLine = d[k];
      repeat (BIT_CLKS) @(negedge clk);
    end
    rxLine = stopVal;
    if (stopVal) repeat (BIT_CLKS) @(negedge clk);
    else begin
      repeat (44) @(negedge clk);
      rxLine = 1'b1;
      repeat (BIT_CLKS - 44) @(negedge clk);
    end
    repeat (BIT_CLKS * 2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] d, prev;
    logic oldStop;
    void'($urandom(32'h1234abcd));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(txLine === 1'b1, "R11 txLine", txLine, 1);
    check({txFlag, rxFlag, rxEnable, stopCheck, rxStopBit, irq} === 6'b0, "R11 flags/enables", {txFlag, rxFlag, rxEnable, stopCheck, rxStopBit, irq}, 0);
    check(rxBuffer === 8'h00, "R11 buffer", rxBuffer, 0);

    // R1/R2 directed corners and random bytes
    txFrame(8'h00, 1'b0);
    cfg(0, 0, 0, 1);
    txFrame(8'hFF, 1'b0);
    for (int i = 0; i < 3; i++) begin
      cfg(0, 0, 0, 1);
      txFrame(8'($urandom), 1'b0);
    end
    // R9 flag persists and ignores a 1 write
    repeat (300) @(negedge clk);
    check(txFlag === 1'b1, "R9 txFlag persists", txFlag, 1);
    cfg(0, 0, 1, 1);
    check(txFlag === 1'b1, "R9 write 1 no effect", txFlag, 1);
    // R10 interrupt
    irqEnable = 1'b1; @(negedge clk);
    check(irq === 1'b1, "R10 irq on txFlag", irq, 1);
    irqEnable = 1'b0; @(negedge clk);
    check(irq === 1'b0, "R10 irq masked", irq, 0);
    cfg(0, 0, 0, 1);
    check(txFlag === 1'b0, "R9 txFlag cleared", txFlag, 0);
    irqEnable = 1'b1; @(negedge clk);
    check(irq === 1'b0, "R10 irq no flags", irq, 0);
    irqEnable = 1'b0;
    // R3 write during frame ignored
    txFrame(8'hA5, 1'b1);
    cfg(0, 0, 0, 1);

    // R4 receiver disabled
    rxFrame(8'h3C, 1'b1);
    check(rxFlag === 1'b0, "R4 no rx while disabled", rxFlag, 0);
    check(rxBuffer === 8'h00, "R4 buffer unchanged", rxBuffer, 0);

    // R5 random reception
    cfg(1, 0, 1, 1);
    check(rxEnable === 1'b1, "R9 cfg enables", rxEnable, 1);
    for (int i = 0; i < 4; i++) begin
      d = (i == 0) ? 8'h01 : 8'($urandom);
      rxFrame(d, 1'b1);
      check(rxFlag === expCommit(1'b0, 1'b0, 1'b1), "R5 rxFlag set", rxFlag, 1);
      check(rxBuffer === d, "R5 buffer data", rxBuffer, d);
      check(rxStopBit === 1'b1, "R5 stop status", rxStopBit, 1);
      irqEnable = 1'b1; @(negedge clk);
      check(irq === 1'b1, "R10 irq on rxFlag", irq, 1);
      irqEnable = 1'b0;
      cfg(1, 0, 1, 0);
      check(rxFlag === 1'b0, "R9 rxFlag cleared", rxFlag, 0);
    end

    // R6 overrun keeps first byte
    rxFrame(8'h5A, 1'b1);
    prev = rxBuffer;
    rxFrame(8'hC3, 1'b1);
    check(rxBuffer === 8'h5A && prev === 8'h5A, "R6 first byte kept", rxBuffer, 8'h5A);
    check(rxFlag === 1'b1, "R6 flag still set", rxFlag, 1);
    cfg(1, 1, 1, 0);

    // R7 stop check
    oldStop = rxStopBit;
    rxFrame(8'h96, 1'b0);
    check(rxFlag === expCommit(1'b0, 1'b1, 1'b0), "R7 bad stop rejected flag", rxFlag, 0);
    check(rxBuffer === 8'h5A, "R7 buffer unchanged", rxBuffer, 8'h5A);
    check(rxStopBit === oldStop, "R7 stop status unchanged", rxStopBit, oldStop);
    cfg(1, 0, 1, 1);
    rxFrame(8'h69, 1'b0);
    check(rxFlag === expCommit(1'b0, 1'b0, 1'b0), "R7 unchecked commit flag", rxFlag, 1);
    check(rxBuffer === 8'h69, "R7 unchecked commit data", rxBuffer, 8'h69);
    check(rxStopBit === 1'b0, "R7 stop status zero", rxStopBit, 0);
    cfg(1, 0, 1, 0);

    // R8 false start, then recovery
    @(negedge clk); rxLine = 1'b0;
    repeat (16) @(negedge clk); rxLine = 1'b1;
    repeat (BIT_CLKS * 11) @(negedge clk);
    check(rxFlag === 1'b0, "R8 false start ignored", rxFlag, 0);
    check(rxBuffer === 8'h69, "R8 buffer unchanged", rxBuffer, 8'h69);
    d = 8'($urandom);
    rxFrame(d, 1'b1);
    check(rxFlag === 1'b1 && rxBuffer === d, "R8 recovery frame", rxBuffer, d);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule